// File: doc/BRIEF.md
# Tower Energy Unpacker

This block turns the compressed trigger codes of a calorimeter tower pair, one electromagnetic (EM) code and one hadronic (HAD) code, into 16-bit linear energies. It also produces an electron-candidate flag from a hadronic-to-electromagnetic ratio cut. It accepts one pair per clock under `in_valid` and returns the result exactly three cycles later under `out_valid`. The pipeline runs without stalls.

The block has two conversion modes. In shift mode, the mantissa of the code is shifted left by its exponent. In piecewise-linear mode, the code selects one of eight segments for its tower type, and the energy is that segment's offset plus its slope times the code. The mode, the ratio `K` and all segment parameters sit in internal registers, written through a simple write-only bus while traffic flows.

Writes land in a shadow bank. A small configuration state machine has two states: `CFG_CLEAN` (shadow equals active) and `CFG_DIRTY` (shadow holds staged writes). Its transitions are:
- `T_STAGE`: `CFG_CLEAN` goes to `CFG_DIRTY` on any write.
- `T_COMMIT`: `CFG_DIRTY` goes to `CFG_CLEAN` on `bx_start` with no write in the same cycle. The shadow bank is copied into the active bank.
- `T_COMMIT_REWRITE`: `CFG_DIRTY` stays in `CFG_DIRTY` on `bx_start` together with a write. The copy takes the shadow as it stood before that write.

The crossing boundary is marked by `bx_start`. Each pair captures every parameter it needs in its first pipeline stage, so a result never combines old and new settings.

Top module: `tower_energy_unpack`

## Requirements
- R1: In shift mode (mode 0), code bits [7:5] are the exponent and bits [4:0] the mantissa, and each tower's energy is mantissa << exponent. For example, 0x23 gives 6 and 0xFF gives 3968.
- R2: In piecewise-linear mode (mode 1), the segment for a code is the highest index s whose breakpoint bp[s] <= code, or segment 0 if no breakpoint matches. The energy is off[s] + slope[s] * code. EM and HAD use separate tables.
- R3: A piecewise-linear result above 65535 is output as 65535.
- R4: `out_electron` is 1 exactly when (E != 0 or H != 0) and H*K <= E, with E and H the output energies. A pair with both energies zero never passes, and equality passes.
- R5: `out_valid` is high in the third cycle after a cycle in which `in_valid` was sampled high, and low otherwise. Back-to-back pairs each produce a result.
- R6: Bus writes have no effect on results until a `bx_start` cycle. The pair sampled in that same cycle still uses the old settings, and pairs sampled in later cycles use the new ones.
- R7: A commit while pairs are in flight does not change those pairs' results.
- R8: After reset, `out_valid`, `out_electron` and both energies are 0, the mode is 0, K is 1 and all segment fields are 0.
- R9: The write address splits into a group in bits [5:3] and an index in bits [2:0]. The groups are:
  - Group 0, index 0: mode in wdata[0].
  - Group 0, index 1: K in wdata[3:0].
  - Groups 2, 3 and 4: EM breakpoint (wdata[7:0]), offset (wdata[15:0]) and slope (wdata[7:0]).
  - Groups 5, 6 and 7: the same three fields for HAD.
  - Group 1 is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tower pair present this cycle |
| in_em_code | input | 8 | Compressed EM code |
| in_had_code | input | 8 | Compressed HAD code |
| bx_start | input | 1 | Crossing boundary; staged settings become active |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 6 | Parameter address (group, index) |
| cfg_wdata | input | 16 | Parameter write data |
| out_valid | output | 1 | Result valid |
| out_em_energy | output | 16 | Linear EM energy |
| out_had_energy | output | 16 | Linear HAD energy |
| out_electron | output | 1 | Electron-candidate flag |

## Verification
The bench drives codes that sit exactly on a breakpoint, below every breakpoint, and far past full scale. A wrong compare direction or a missing saturation then shows up as a wrong segment or a wrapped-around energy. For the cut, it tries H*K equal to E, a zero pair, and a pair with E above zero and H zero. A strict compare, or a missing zero-pair guard, would flip the flag. It also stages writes without a boundary and streams three pairs around a `bx_start`. A design that applied writes at once, or that read parameters late in the pipeline, would show new values in the wrong pair or a mix of old and new values in one result.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    typedef enum logic {
        CFG_CLEAN = 1'b0,
        CFG_DIRTY = 1'b1
    } cfg_state_e;

    localparam logic MODE_SHIFT = 1'b0;
    localparam logic MODE_PWL   = 1'b1;

    localparam int GRP_W = 3;
    localparam logic [GRP_W-1:0] GRP_CTRL     = 3'd0;
    localparam logic [GRP_W-1:0] GRP_EM_BP    = 3'd2;
    localparam logic [GRP_W-1:0] GRP_EM_OFF   = 3'd3;
    localparam logic [GRP_W-1:0] GRP_EM_SLOPE = 3'd4;
    localparam logic [GRP_W-1:0] GRP_HD_BP    = 3'd5;
    localparam logic [GRP_W-1:0] GRP_HD_OFF   = 3'd6;
    localparam logic [GRP_W-1:0] GRP_HD_SLOPE = 3'd7;

endpackage

// File: rtl/tpd_cfg.sv
module tpd_cfg
    import tpd_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int EN_W    = 16,
    parameter int NSEG    = 8,
    parameter int SLOPE_W = 8,
    parameter int RATIO_W = 4,
    localparam int SEG_W  = $clog2(NSEG),
    localparam int ADDR_W = SEG_W + GRP_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bx_start,
    input  logic                             cfg_we,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [EN_W-1:0]                  cfg_wdata,
    output logic                             act_mode,
    output logic [RATIO_W-1:0]               act_k,
    output logic [NSEG-1:0][CODE_W-1:0]      em_bp,
    output logic [NSEG-1:0][EN_W-1:0]        em_off,
    output logic [NSEG-1:0][SLOPE_W-1:0]     em_slope,
    output logic [NSEG-1:0][CODE_W-1:0]      hd_bp,
    output logic [NSEG-1:0][EN_W-1:0]        hd_off,
    output logic [NSEG-1:0][SLOPE_W-1:0]     hd_slope
);

    cfg_state_e state_q, state_d;
    logic       commit;

    logic                         sh_mode;
    logic [RATIO_W-1:0]           sh_k;
    logic [NSEG-1:0][CODE_W-1:0]  sh_em_bp,    sh_hd_bp;
    logic [NSEG-1:0][EN_W-1:0]    sh_em_off,   sh_hd_off;
    logic [NSEG-1:0][SLOPE_W-1:0] sh_em_slope, sh_hd_slope;

    logic [GRP_W-1:0] grp;
    logic [SEG_W-1:0] idx;

    assign grp = cfg_addr[ADDR_W-1:SEG_W];
    assign idx = cfg_addr[SEG_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_CLEAN;
        else        state_q <= state_d;
    end

    // Transitions: T_STAGE, T_COMMIT, T_COMMIT_REWRITE
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            CFG_CLEAN: begin
                if (cfg_we) state_d = CFG_DIRTY;
            end
            CFG_DIRTY: begin
                if (bx_start) begin
                    commit  = 1'b1;
                    state_d = cfg_we ? CFG_DIRTY : CFG_CLEAN;
                end
            end
            default: state_d = CFG_CLEAN;
        endcase
    end

    // Shadow bank: bus writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mode     <= MODE_SHIFT;
            sh_k        <= RATIO_W'(1);
            sh_em_bp    <= '0;
            sh_em_off   <= '0;
            sh_em_slope <= '0;
            sh_hd_bp    <= '0;
            sh_hd_off   <= '0;
            sh_hd_slope <= '0;
        end else if (cfg_we) begin
            unique case (grp)
                GRP_CTRL: begin
                    if (idx == SEG_W'(0)) sh_mode <= cfg_wdata[0];
                    if (idx == SEG_W'(1)) sh_k    <= cfg_wdata[RATIO_W-1:0];
                end
                GRP_EM_BP:    sh_em_bp[idx]    <= cfg_wdata[CODE_W-1:0];
                GRP_EM_OFF:   sh_em_off[idx]   <= cfg_wdata;
                GRP_EM_SLOPE: sh_em_slope[idx] <= cfg_wdata[SLOPE_W-1:0];
                GRP_HD_BP:    sh_hd_bp[idx]    <= cfg_wdata[CODE_W-1:0];
                GRP_HD_OFF:   sh_hd_off[idx]   <= cfg_wdata;
                GRP_HD_SLOPE: sh_hd_slope[idx] <= cfg_wdata[SLOPE_W-1:0];
                default: ;
            endcase
        end
    end

    // Active bank: output process driven by the commit decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= MODE_SHIFT;
            act_k    <= RATIO_W'(1);
            em_bp    <= '0;
            em_off   <= '0;
            em_slope <= '0;
            hd_bp    <= '0;
            hd_off   <= '0;
            hd_slope <= '0;
        end else if (commit) begin
            act_mode <= sh_mode;
            act_k    <= sh_k;
            em_bp    <= sh_em_bp;
            em_off   <= sh_em_off;
            em_slope <= sh_em_slope;
            hd_bp    <= sh_hd_bp;
            hd_off   <= sh_hd_off;
            hd_slope <= sh_hd_slope;
        end
    end

endmodule

// File: rtl/tpd_lane.sv
module tpd_lane
    import tpd_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int MANT_W  = 5,
    parameter int EN_W    = 16,
    parameter int NSEG    = 8,
    parameter int SLOPE_W = 8,
    localparam int SEG_W  = $clog2(NSEG),
    localparam int EXP_W  = CODE_W - MANT_W,
    localparam int WIDE   = EN_W + SLOPE_W + CODE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_s1,
    input  logic                         load_s2,
    input  logic                         mode_s1,
    input  logic [CODE_W-1:0]            code,
    input  logic [NSEG-1:0][CODE_W-1:0]  bp,
    input  logic [NSEG-1:0][EN_W-1:0]    off,
    input  logic [NSEG-1:0][SLOPE_W-1:0] slope,
    output logic [EN_W-1:0]              energy
);

    logic [SEG_W-1:0]   sel;
    logic [CODE_W-1:0]  code_q;
    logic [EN_W-1:0]    off_q;
    logic [SLOPE_W-1:0] slope_q;
    logic [WIDE-1:0]    shift_val, pwl_val, raw;
    logic [EN_W-1:0]    sat_val;

    // Priority select: highest segment whose breakpoint does not exceed the code
    always_comb begin
        sel = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (code >= bp[s]) sel = SEG_W'(s);
        end
    end

    // Stage 1: capture code and the selected segment's parameters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            off_q   <= '0;
            slope_q <= '0;
        end else if (load_s1) begin
            code_q  <= code;
            off_q   <= off[sel];
            slope_q <= slope[sel];
        end
    end

    // Stage 2: expand, then clamp at full scale
    always_comb begin
        shift_val = WIDE'(code_q[MANT_W-1:0]) << code_q[CODE_W-1:CODE_W-EXP_W];
        pwl_val   = WIDE'(off_q) + WIDE'(slope_q) * WIDE'(code_q);
        raw       = (mode_s1 == MODE_PWL) ? pwl_val : shift_val;
        sat_val   = (|raw[WIDE-1:EN_W]) ? {EN_W{1'b1}} : raw[EN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       energy <= '0;
        else if (load_s2) energy <= sat_val;
    end

endmodule

// File: rtl/tower_energy_unpack.sv
module tower_energy_unpack
    import tpd_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int MANT_W  = 5,
    parameter int EN_W    = 16,
    parameter int NSEG    = 8,
    parameter int SLOPE_W = 8,
    parameter int RATIO_W = 4,
    localparam int ADDR_W = $clog2(NSEG) + GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_em_code,
    input  logic [CODE_W-1:0] in_had_code,
    input  logic              bx_start,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [EN_W-1:0]   cfg_wdata,
    output logic              out_valid,
    output logic [EN_W-1:0]   out_em_energy,
    output logic [EN_W-1:0]   out_had_energy,
    output logic              out_electron
);

    localparam int PROD_W = EN_W + RATIO_W;
    localparam int NLANE  = 2;

    logic                         act_mode;
    logic [RATIO_W-1:0]           act_k;
    logic [NSEG-1:0][CODE_W-1:0]  em_bp,    hd_bp;
    logic [NSEG-1:0][EN_W-1:0]    em_off,   hd_off;
    logic [NSEG-1:0][SLOPE_W-1:0] em_slope, hd_slope;

    logic               v1, v2, v3;
    logic               mode1, mode2, mode3;
    logic [RATIO_W-1:0] k1, k2;
    logic [EN_W-1:0]    lane_energy [NLANE];
    logic [PROD_W-1:0]  had_scaled;
    logic               pass;

    tpd_cfg #(
        .CODE_W(CODE_W), .EN_W(EN_W), .NSEG(NSEG),
        .SLOPE_W(SLOPE_W), .RATIO_W(RATIO_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .bx_start(bx_start),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .act_mode(act_mode), .act_k(act_k),
        .em_bp(em_bp), .em_off(em_off), .em_slope(em_slope),
        .hd_bp(hd_bp), .hd_off(hd_off), .hd_slope(hd_slope)
    );

    // One conversion lane per tower type
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        tpd_lane #(
            .CODE_W(CODE_W), .MANT_W(MANT_W), .EN_W(EN_W),
            .NSEG(NSEG), .SLOPE_W(SLOPE_W)
        ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .load_s1(in_valid), .load_s2(v1), .mode_s1(mode1),
            .code (g == 0 ? in_em_code : in_had_code),
            .bp   (g == 0 ? em_bp      : hd_bp),
            .off  (g == 0 ? em_off     : hd_off),
            .slope(g == 0 ? em_slope   : hd_slope),
            .energy(lane_energy[g])
        );
    end

    // Control pipeline: valid, mode and ratio travel with the pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
            mode1 <= MODE_SHIFT; mode2 <= MODE_SHIFT; mode3 <= MODE_SHIFT;
            k1 <= '0; k2 <= '0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
            if (in_valid) begin
                mode1 <= act_mode;
                k1    <= act_k;
            end
            if (v1) begin
                mode2 <= mode1;
                k2    <= k1;
            end
            if (v2) mode3 <= mode2;
        end
    end

    // Ratio cut without a divider
    always_comb begin
        had_scaled = PROD_W'(lane_energy[1]) * PROD_W'(k2);
        pass = ((lane_energy[0] != '0) || (lane_energy[1] != '0))
               && (had_scaled <= PROD_W'(lane_energy[0]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_em_energy  <= '0;
            out_had_energy <= '0;
            out_electron   <= 1'b0;
        end else if (v2) begin
            out_em_energy  <= lane_energy[0];
            out_had_energy <= lane_energy[1];
            out_electron   <= pass;
        end
    end

    assign out_valid = v3;

endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
    parameter int CODE_W  = 8,
    parameter int MANT_W  = 5,
    parameter int EN_W    = 16,
    parameter int RATIO_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               bx_start,
    input logic               out_valid,
    input logic               out_electron,
    input logic               out_mode,
    input logic               act_mode,
    input logic [RATIO_W-1:0] act_k,
    input logic [EN_W-1:0]    out_em,
    input logic [EN_W-1:0]    out_had
);

    localparam int EXP_W = CODE_W - MANT_W;
    localparam logic [EN_W-1:0] SHIFT_MAX =
        EN_W'(((1 << MANT_W) - 1) << ((1 << EXP_W) - 1));

    // R5: a sampled pair yields a result three cycles on
    p_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R5: no result appears without a pair
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R4: a pair with both energies zero never passes the cut
    p_zero_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_em == '0 && out_had == '0) |-> !out_electron);

    // R1: shift-mode results stay within the largest shifted mantissa
    p_shift_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_mode) |-> (out_em <= SHIFT_MAX && out_had <= SHIFT_MAX));

    // R6: active settings change only at a crossing boundary
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bx_start |=> ($stable(act_mode) && $stable(act_k)));

endmodule

bind tower_energy_unpack tpd_checker #(
    .CODE_W(CODE_W), .MANT_W(MANT_W), .EN_W(EN_W), .RATIO_W(RATIO_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bx_start(bx_start),
    .out_valid(out_valid), .out_electron(out_electron), .out_mode(mode3),
    .act_mode(act_mode), .act_k(act_k),
    .out_em(out_em_energy), .out_had(out_had_energy)
);

// File: tb/tower_energy_unpack_bench.sv
module tower_energy_unpack_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_em_code = '0;
    logic [7:0]  in_had_code = '0;
    logic        bx_start = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        out_valid;
    logic [15:0] out_em_energy;
    logic [15:0] out_had_energy;
    logic        out_electron;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench-side settings model: index 0 = EM, 1 = HAD
    int sh_mode = 0, act_mode = 0, sh_k = 1, act_k = 1;
    int sh_bp [2][8], sh_off [2][8], sh_sl [2][8];
    int ac_bp [2][8], ac_off [2][8], ac_sl [2][8];

    always #5 clk = ~clk;

    tower_energy_unpack u_tower_energy_unpack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_em_code(in_em_code), .in_had_code(in_had_code),
        .bx_start(bx_start), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_em_energy(out_em_energy), .out_had_energy(out_had_energy),
        .out_electron(out_electron)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int conv(input int t, input int code);
        int sel, v;
        if (act_mode == 0) return (code & 31) << (code >> 5);
        sel = 0;
        for (int s = 0; s < 8; s++) if (code >= ac_bp[t][s]) sel = s;
        v = ac_off[t][sel] + ac_sl[t][sel] * code;
        return (v > 65535) ? 65535 : v;
    endfunction

    function automatic int cut(input int e, input int h);
        return ((e != 0 || h != 0) && (h * act_k <= e)) ? 1 : 0;
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R9 address map
    task automatic set_mode(input int m);
        wr(6'h00, m); sh_mode = m;
    endtask

    task automatic set_k(input int k);
        wr(6'h01, k); sh_k = k;
    endtask

    task automatic set_seg(input int t, input int s, input int bp, input int off, input int sl);
        int base;
        base = (t == 0) ? 8'h10 : 8'h28;
        wr(base + s, bp);
        wr(base + 8 + s, off);
        wr(base + 16 + s, sl);
        sh_bp[t][s] = bp; sh_off[t][s] = off; sh_sl[t][s] = sl;
    endtask

    task automatic boundary();
        @(negedge clk);
        bx_start = 1'b1;
        @(negedge clk);
        bx_start = 1'b0;
        act_mode = sh_mode; act_k = sh_k;
        ac_bp = sh_bp; ac_off = sh_off; ac_sl = sh_sl;
    endtask

    // Single pair with latency checks (R5) and result checks under tag
    task automatic run_pair(input int ec, input int hc, input string tag);
        int xe, xh, xl;
        xe = conv(0, ec); xh = conv(1, hc); xl = cut(xe, xh);
        @(negedge clk);
        in_valid = 1'b1; in_em_code = 8'(ec); in_had_code = 8'(hc);
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 valid +1", int'(out_valid), 0);
        @(negedge clk);
        check("R5 valid +2", int'(out_valid), 0);
        @(negedge clk);
        check("R5 valid +3", int'(out_valid), 1);
        check({tag, " em"}, int'(out_em_energy), xe);
        check({tag, " had"}, int'(out_had_energy), xh);
        check({tag, " electron R4"}, int'(out_electron), xl);
        @(negedge clk);
        check("R5 valid +4", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        check("R8 out_valid", int'(out_valid), 0);
        check("R8 em", int'(out_em_energy), 0);
        check("R8 had", int'(out_had_energy), 0);
        check("R8 electron", int'(out_electron), 0);
        run_pair(8'h0A, 8'h05, "R8 default shift K=1");
    endtask

    task automatic t_shift();
        run_pair(8'hFF, 8'h23, "R1 full code");
        run_pair(8'h41, 8'hE1, "R1 exp mix");
        run_pair(8'h00, 8'h1F, "R1 zero em");
    endtask

    task automatic t_cut();
        set_k(2); boundary();
        run_pair(8'h0A, 8'h05, "R4 equal passes");
        set_k(3); boundary();
        run_pair(8'h0A, 8'h05, "R4 above fails");
        run_pair(8'h00, 8'h00, "R4 zero pair");
        run_pair(8'h01, 8'h00, "R4 h zero");
    endtask

    task automatic t_shadow();
        set_mode(1);
        for (int s = 0; s < 8; s++) begin
            set_seg(0, s, s * 32, (s == 7) ? 16'hFF00 : s * 1000, (s == 7) ? 255 : s + 1);
            set_seg(1, s, s * 16, s * 100, 2);
        end
        run_pair(8'h64, 8'h64, "R6 staged not applied");
        check("R6 mode still shift", act_mode, 0);
        boundary();
        run_pair(8'h64, 8'h64, "R6 applied R2 mid seg");
    endtask

    task automatic t_pwl();
        run_pair(8'd32, 8'd16, "R2 on breakpoint");
        run_pair(8'd0, 8'd15, "R2 low end");
        run_pair(8'd250, 8'd255, "R3 saturate");
        run_pair(8'd224, 8'd200, "R3 seg7 start");
        set_seg(1, 0, 8, 0, 2); boundary();
        run_pair(8'd40, 8'd3, "R2 below all bps");
    endtask

    // Three back-to-back pairs around a commit
    task automatic t_nomix();
        int xe [3], xh [3], xl [3];
        int ce [3], ch [3];
        ce = '{100, 33, 200}; ch = '{20, 5, 50};
        set_mode(0);
        for (int i = 0; i < 2; i++) begin
            xe[i] = conv(0, ce[i]); xh[i] = conv(1, ch[i]); xl[i] = cut(xe[i], xh[i]);
        end
        act_mode = sh_mode; act_k = sh_k;
        xe[2] = conv(0, ce[2]); xh[2] = conv(1, ch[2]); xl[2] = cut(xe[2], xh[2]);
        @(negedge clk);
        in_valid = 1'b1; in_em_code = 8'(ce[0]); in_had_code = 8'(ch[0]);
        @(negedge clk);
        in_em_code = 8'(ce[1]); in_had_code = 8'(ch[1]); bx_start = 1'b1;
        @(negedge clk);
        in_em_code = 8'(ce[2]); in_had_code = 8'(ch[2]); bx_start = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (i > 0) @(negedge clk);
            check("R7 stream valid", int'(out_valid), 1);
            check(i < 2 ? "R7 in-flight em" : "R6 post-commit em", int'(out_em_energy), xe[i]);
            check(i < 2 ? "R7 in-flight had" : "R6 post-commit had", int'(out_had_energy), xh[i]);
            check("R7 stream electron R4", int'(out_electron), xl[i]);
        end
        @(negedge clk);
        check("R5 stream end", int'(out_valid), 0);
    endtask

    initial begin
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 8; s++) begin
                sh_bp[t][s] = 0; sh_off[t][s] = 0; sh_sl[t][s] = 0;
                ac_bp[t][s] = 0; ac_off[t][s] = 0; ac_sl[t][s] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shift();
        t_cut();
        t_shadow();
        t_pwl();
        t_nomix();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R5: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule